// File: doc/BRIEF.md
# Bidirectional Byte Transceiver with Parity Generation and Checking

This block moves one byte between two buses, A and B, in a direction picked by a single control input. With that input high, the byte on A is driven onto B. With it low, the byte on B is driven onto A. The data paths do not invert. An active-low chip enable turns every driver in the block off: both data ports, the parity pin and the error flag.

A shared parity pin changes role with the direction. When sending, the block drives it with a parity bit computed from the A byte. When receiving, the pin is an input, and the block checks it together with the B byte. An odd/even select sets the rule. With the select high, the nine bits (byte plus parity) must hold an odd number of ones. With the select low, they must hold an even number. The error flag is active low, so a high level means the parity is good. The flag is driven only while receiving.

The block is purely combinational. Each bidirectional pin is split into an input, an output value and an output enable, which pad cells or a bus fabric outside the block combine.

Top module: `xcvr_parity_top`

## Requirements
- R1: With `oe_n_i` low and `dir_i` high (send), `b_out_o` equals `a_in_i` bit for bit, `b_oe_o` is 1 and `a_oe_o` is 0.
- R2: With `oe_n_i` low and `dir_i` low (receive), `a_out_o` equals `b_in_i` bit for bit, `a_oe_o` is 1 and `b_oe_o` is 0.
- R3: With `oe_n_i` high, `a_oe_o`, `b_oe_o`, `par_oe_o` and `err_oe_o` are all 0, whatever the other inputs are.
- R4: When sending and enabled, `par_oe_o` is 1 and `err_oe_o` is 0. `par_out_o` is chosen so that the ones in `a_in_i` plus `par_out_o` add up to an odd number when `odd_sel_i` is 1 and to an even number when `odd_sel_i` is 0. So with the select high and an even count on A, the parity output is 1.
- R5: When receiving and enabled, `err_oe_o` is 1 and `par_oe_o` is 0. `err_n_out_o` is 1 (no error) when the ones in `b_in_i` plus `par_in_i` add up to an odd number with `odd_sel_i` at 1, or to an even number with `odd_sel_i` at 0. Otherwise it is 0.
- R6: Any output value whose enable is 0 reads 0. This covers `a_out_o`, `b_out_o`, `par_out_o` and `err_n_out_o`.
- R7: When sending, `b_in_i` and `par_in_i` have no effect on any output. When receiving, `a_in_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_i | input | 1 | 1 = send (A to B), 0 = receive (B to A) |
| oe_n_i | input | 1 | Active-low enable; 1 turns off every driver |
| odd_sel_i | input | 1 | 1 = odd parity over nine bits, 0 = even parity |
| a_in_i | input | WIDTH | Value seen on the A pins |
| a_out_o | output | WIDTH | Value driven onto the A pins |
| a_oe_o | output | 1 | Driver enable for the A pins |
| b_in_i | input | WIDTH | Value seen on the B pins |
| b_out_o | output | WIDTH | Value driven onto the B pins |
| b_oe_o | output | 1 | Driver enable for the B pins |
| par_in_i | input | 1 | Value seen on the parity pin |
| par_out_o | output | 1 | Generated parity driven onto the parity pin |
| par_oe_o | output | 1 | Driver enable for the parity pin |
| err_n_out_o | output | 1 | Active-low parity error flag value |
| err_oe_o | output | 1 | Driver enable for the error flag |

## Verification
Every result is a combinational function of the inputs present in the same cycle, so each output is due zero cycles after its stimulus. The bench applies a new input set just after each rising edge and compares all outputs at the following falling edge. By then the logic has settled, and no register lies between stimulus and result. Every data value is swept against every combination of direction, select, parity input and enable. The unused input on each side carries an unrelated pattern, so an input that should be ignored and still leaks into an output shows up as a mismatch.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

  // Parity bit that makes the nine-bit total odd (odd_sel=1) or even (odd_sel=0).
  function automatic logic gen_parity(input logic data_ones_odd, input logic odd_sel);
    return data_ones_odd ^ ~odd_sel ^ 1'b1;
  endfunction

  // High when the received byte plus its parity bit obey the selected rule.
  function automatic logic parity_good(input logic data_ones_odd, input logic par_bit,
                                       input logic odd_sel);
    return (data_ones_odd ^ par_bit) == odd_sel;
  endfunction

endpackage

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
  import xcvr_pkg::*;
(
  input  logic dir_i,
  input  logic oe_n_i,
  output logic tx_en_o,
  output logic rx_en_o
);

  logic chip_en;
  dir_e dir;

  assign chip_en = ~oe_n_i;
  assign dir     = dir_e'(dir_i);
  assign tx_en_o = chip_en && (dir == DIR_TX);
  assign rx_en_o = chip_en && (dir == DIR_RX);

  always_comb begin
    p_one_direction_r1: assert (!(tx_en_o && rx_en_o))
      else $error("both directions enabled");
    p_off_when_disabled_r3: assert (!oe_n_i || (!tx_en_o && !rx_en_o))
      else $error("direction enable while chip disabled");
  end

endmodule

// File: rtl/xcvr_data_path.sv
module xcvr_data_path #(
  parameter int WIDTH = 8
) (
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  input  logic [WIDTH-1:0] a_in_i,
  input  logic [WIDTH-1:0] b_in_i,
  output logic [WIDTH-1:0] a_out_o,
  output logic [WIDTH-1:0] b_out_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign b_out_o[i] = tx_en_i & a_in_i[i];
    assign a_out_o[i] = rx_en_i & b_in_i[i];
  end

  always_comb begin
    p_tx_copy_r1: assert (!tx_en_i || (b_out_o == a_in_i))
      else $error("B output differs from A input while sending");
    p_rx_copy_r2: assert (!rx_en_i || (a_out_o == b_in_i))
      else $error("A output differs from B input while receiving");
    p_idle_zero_r6: assert ((tx_en_i || b_out_o == '0) && (rx_en_i || a_out_o == '0))
      else $error("undriven data port carries a nonzero value");
  end

endmodule

// File: rtl/xcvr_parity.sv
module xcvr_parity
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  input  logic             odd_sel_i,
  input  logic [WIDTH-1:0] a_in_i,
  input  logic [WIDTH-1:0] b_in_i,
  input  logic             par_in_i,
  output logic             par_out_o,
  output logic             par_oe_o,
  output logic             err_n_out_o,
  output logic             err_oe_o
);

  logic a_ones_odd;
  logic b_ones_odd;
  logic gen_bit;
  logic chk_good;

  assign a_ones_odd = ^a_in_i;
  assign b_ones_odd = ^b_in_i;
  assign gen_bit    = gen_parity(a_ones_odd, odd_sel_i);
  assign chk_good   = parity_good(b_ones_odd, par_in_i, odd_sel_i);

  assign par_oe_o    = tx_en_i;
  assign par_out_o   = tx_en_i & gen_bit;
  assign err_oe_o    = rx_en_i;
  assign err_n_out_o = rx_en_i & chk_good;

  always_comb begin
    p_gen_total_r4: assert (!par_oe_o || ((a_ones_odd ^ par_out_o) == odd_sel_i))
      else $error("generated parity breaks the selected rule");
    p_pin_roles_r5: assert (!(par_oe_o && err_oe_o))
      else $error("parity pin and error flag driven together");
    p_chk_rule_r5: assert (!err_oe_o || (err_n_out_o == ((b_ones_odd ^ par_in_i) == odd_sel_i)))
      else $error("error flag disagrees with received parity");
  end

endmodule

// File: rtl/xcvr_parity_top.sv
module xcvr_parity_top
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             dir_i,
  input  logic             oe_n_i,
  input  logic             odd_sel_i,
  input  logic [WIDTH-1:0] a_in_i,
  output logic [WIDTH-1:0] a_out_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_in_i,
  output logic [WIDTH-1:0] b_out_o,
  output logic             b_oe_o,
  input  logic             par_in_i,
  output logic             par_out_o,
  output logic             par_oe_o,
  output logic             err_n_out_o,
  output logic             err_oe_o
);

  logic tx_en;
  logic rx_en;

  xcvr_dir_ctrl i_ctrl (
    .dir_i   (dir_i),
    .oe_n_i  (oe_n_i),
    .tx_en_o (tx_en),
    .rx_en_o (rx_en)
  );

  xcvr_data_path #(.WIDTH(WIDTH)) i_data (
    .tx_en_i (tx_en),
    .rx_en_i (rx_en),
    .a_in_i  (a_in_i),
    .b_in_i  (b_in_i),
    .a_out_o (a_out_o),
    .b_out_o (b_out_o)
  );

  xcvr_parity #(.WIDTH(WIDTH)) i_par (
    .tx_en_i     (tx_en),
    .rx_en_i     (rx_en),
    .odd_sel_i   (odd_sel_i),
    .a_in_i      (a_in_i),
    .b_in_i      (b_in_i),
    .par_in_i    (par_in_i),
    .par_out_o   (par_out_o),
    .par_oe_o    (par_oe_o),
    .err_n_out_o (err_n_out_o),
    .err_oe_o    (err_oe_o)
  );

  assign b_oe_o = tx_en;
  assign a_oe_o = rx_en;

  always_comb begin
    p_disabled_r3: assert (!oe_n_i || !(a_oe_o || b_oe_o || par_oe_o || err_oe_o))
      else $error("driver enabled while chip disabled");
    p_dest_only_r2: assert ($countones({a_oe_o, b_oe_o}) <= 1)
      else $error("both data ports driven");
  end

endmodule

// File: tb/test_xcvr_parity_top.sv
module test_xcvr_parity_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         dir, oe_n, odd_sel, par_in;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe, par_out, par_oe, err_n, err_oe;

  int  tests  = 0;
  int  fails  = 0;
  int  cycles = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  xcvr_parity_top #(.WIDTH(W)) i_xcvr_parity_top (
    .dir_i(dir), .oe_n_i(oe_n), .odd_sel_i(odd_sel),
    .a_in_i(a_in), .a_out_o(a_out), .a_oe_o(a_oe),
    .b_in_i(b_in), .b_out_o(b_out), .b_oe_o(b_oe),
    .par_in_i(par_in), .par_out_o(par_out), .par_oe_o(par_oe),
    .err_n_out_o(err_n), .err_oe_o(err_oe)
  );

  function automatic int ones(input logic [W-1:0] v);
    int n = 0;
    for (int k = 0; k < W; k++) if (v[k]) n++;
    return n;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  // Reference model: drivers, values and flags from the requirements.
  task automatic compare();
    int          n;
    bit          en, tx, rx;
    logic [W-1:0] ea, eb;
    logic        epar, eerr;
    en = !oe_n;
    tx = en && dir;
    rx = en && !dir;
    ea = rx ? b_in : '0;
    eb = tx ? a_in : '0;
    n = ones(a_in);
    epar = 1'b0;
    if (tx) epar = ((n % 2 == 1) == odd_sel) ? 1'b0 : 1'b1;
    n = ones(b_in) + (par_in ? 1 : 0);
    eerr = 1'b0;
    if (rx) eerr = ((n % 2 == 1) == odd_sel) ? 1'b1 : 1'b0;
    if (oe_n) begin
      check("R3", "all enables", int'({a_oe, b_oe, par_oe, err_oe}), 0);
    end else if (dir) begin
      check("R1", "b_out", int'(b_out), int'(eb));
      check("R1", "b_oe/a_oe", int'({b_oe, a_oe}), 2);
      check("R4", "par_out", int'(par_out), int'(epar));
      check("R4", "par_oe/err_oe", int'({par_oe, err_oe}), 2);
      check("R7", "a_out with ignored inputs", int'(a_out), 0);
    end else begin
      check("R2", "a_out", int'(a_out), int'(ea));
      check("R2", "a_oe/b_oe", int'({a_oe, b_oe}), 2);
      check("R5", "err_n_out", int'(err_n), int'(eerr));
      check("R5", "err_oe/par_oe", int'({err_oe, par_oe}), 2);
      check("R7", "b_out with ignored a_in", int'(b_out), 0);
    end
    check("R6", "idle output values",
          int'({a_oe ? 8'h00 : a_out, b_oe ? 8'h00 : b_out, par_oe ? 1'b0 : par_out,
                err_oe ? 1'b0 : err_n}), 0);
  endtask

  initial begin
    dir = 1'b0; oe_n = 1'b1; odd_sel = 1'b0; par_in = 1'b0;
    a_in = '0; b_in = '0;
    @(negedge clk);
    // Reset state: disabled, every driver off (R3) and every value zero (R6).
    check("R3", "initial enables", int'({a_oe, b_oe, par_oe, err_oe}), 0);
    check("R6", "initial values", int'({a_out, b_out, par_out, err_n}), 0);
    // Fixed corner cases from R4 and R5.
    @(posedge clk); #1;
    oe_n = 1'b0; dir = 1'b1; odd_sel = 1'b1; a_in = 8'h03; b_in = 8'h00;
    @(negedge clk);
    check("R4", "even A count, odd select", int'(par_out), 1);
    @(posedge clk); #1;
    dir = 1'b0; b_in = 8'h0F; par_in = 1'b1;
    @(negedge clk);
    check("R5", "even B count, parity 1, odd select", int'(err_n), 1);
    @(posedge clk); #1;
    b_in = 8'h07;
    @(negedge clk);
    check("R5", "odd B count, parity 1, odd select", int'(err_n), 0);
    // Exhaustive sweep.
    for (int e = 0; e < 2; e++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 2; s++)
          for (int p = 0; p < 2; p++)
            for (int v = 0; v < 256; v++) begin
              @(posedge clk); #1;
              oe_n = e[0]; dir = d[0]; odd_sel = s[0]; par_in = p[0];
              if (d == 1) begin
                a_in = v[W-1:0];
                b_in = ~{v[3:0], v[7:4]} ^ 8'h5A;
              end else begin
                b_in = v[W-1:0];
                a_in = {v[0], v[7:1]} ^ 8'hC3;
              end
              @(negedge clk);
              compare();
            end
    done = 1'b1;
    summary();
  end

endmodule